// File: doc/BRIEF.md
# Tug-of-War Game Controller

This block runs a two-player tug-of-war game on a row of nine indicator lamps. Exactly one lamp is lit, and it stands for the knot in the rope. Each player has one push button. Every clean press that the block accepts pulls the lit lamp one place toward that player's end. When the light arrives at a player's end lamp, that player takes the round. The game then freezes until a round reset re-centres the light.

Both buttons are first synchronised to the clock. They are then filtered, so that contact bounce cannot produce extra steps. For each player the block keeps a single decimal digit that counts the rounds won, for an external numeric display. These digits survive a round reset. Only the full asynchronous clear sets them back to zero.

Top module: `tow_game`

## Requirements
- R1: After the full clear (`rst_n` low), `lamp` equals 9'b000010000 (only index 4 lit), `won_a` and `won_b` are low, and both win digits read 0.
- R2: `lamp` has exactly one bit set in every cycle. Bit 0 is player A's end and bit 8 is player B's end.
- R3: Each accepted press from A moves the lit index down by one. Each accepted press from B moves it up by one.
- R4: When A and B presses are accepted in the same clock cycle, the two moves cancel and the lit index does not change.
- R5: `won_a` is high exactly while the lit index is 0. `won_b` is high exactly while the lit index is 8.
- R6: Once a round is won, further presses from either player leave `lamp` and both win digits unchanged.
- R7: A one-cycle high on `round_clr` puts the light back on index 4, clears `won_a` and `won_b`, and leaves both win digits as they were.
- R8: The winner's digit rises by exactly one per won round. It changes on the same clock edge on which the light reaches that player's end.
- R9: Each win digit is a BCD value from 0 to 9. It holds at 9 when further rounds are won.
- R10: A press is accepted only after the synchronised button level has stayed the same for `STABLE_CYCLES` clocks (500000 at 50 MHz, 10 ms). A shorter pulse does nothing, and holding the button down gives only one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low full clear, including the win digits |
| round_clr | input | 1 | Synchronous round reset: re-centres the light and clears the win flags |
| btn_a | input | 1 | Player A push button, active high, asynchronous |
| btn_b | input | 1 | Player B push button, active high, asynchronous |
| lamp | output | 9 | One-hot rope position, bit 0 = A's end |
| won_a | output | 1 | Player A holds the current round |
| won_b | output | 1 | Player B holds the current round |
| wins_a | output | 4 | BCD count of rounds won by A |
| wins_b | output | 4 | BCD count of rounds won by B |

## Verification
Two functions can land in the same clock cycle: player A's accepted step and player B's accepted step. Both buttons pass through identical filters. The bench therefore drives both buttons high on the same falling edge, which makes the two accept pulses fall on the same clock edge. The test is repeated while play is live and again after a win, when the lock must win out. In both cases the bench reads `lamp` after the filters have settled and expects the same one-hot value as before the press.

// File: rtl/tow_pkg.sv
package tow_pkg;

  // Next rope index: A pulls toward 0, B toward last; both cancel.
  function automatic logic [3:0] rope_next(input logic [3:0] pos,
                                           input logic pull_a,
                                           input logic pull_b);
    logic [3:0] r;
    r = pos;
    if (pull_a && !pull_b) r = pos - 4'd1;
    else if (pull_b && !pull_a) r = pos + 4'd1;
    return r;
  endfunction

  // True when an index is either end of the rope.
  function automatic logic at_end(input logic [3:0] pos, input logic [3:0] last);
    return (pos == 4'd0) || (pos == last);
  endfunction

  // BCD digit increment that holds at the top value.
  function automatic logic [3:0] digit_bump(input logic [3:0] d, input logic [3:0] top);
    return (d >= top) ? top : d + 4'd1;
  endfunction

endpackage

// File: rtl/tow_btn_filter.sv
module tow_btn_filter #(
  parameter int STABLE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYCLES - 1);

  logic s1, s2, level;
  logic [CW-1:0] cnt;
  logic settle;

  assign settle = (s2 != level) && (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      level <= 1'b0;
      cnt <= '0;
      press <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      press <= settle && s2;
      if (s2 == level) cnt <= '0;
      else if (settle) begin
        level <= s2;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  // R10: an accept pulse lasts a single cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
  // R10: a pulse appears only when the filtered level has just gone high
  p_press_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> level);
endmodule

// File: rtl/tow_rope.sv
module tow_rope #(
  parameter int LAMPS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             round_clr,
  input  logic             pull_a,
  input  logic             pull_b,
  output logic [LAMPS-1:0] lamp,
  output logic             won_a,
  output logic             won_b,
  output logic             take_a,
  output logic             take_b
);
  import tow_pkg::*;
  localparam logic [3:0] LAST = 4'(LAMPS - 1);
  localparam logic [3:0] MID  = 4'((LAMPS - 1) / 2);

  logic [3:0] pos, nxt;
  logic locked, live;

  assign locked = at_end(pos, LAST);
  assign live   = !locked && !round_clr;
  assign nxt    = rope_next(pos, pull_a, pull_b);
  assign take_a = live && (nxt == 4'd0);
  assign take_b = live && (nxt == LAST);
  assign won_a  = (pos == 4'd0);
  assign won_b  = (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= MID;
    else if (round_clr) pos <= MID;
    else if (!locked) pos <= nxt;
  end

  for (genvar i = 0; i < LAMPS; i++) begin : g_lamp
    assign lamp[i] = (pos == 4'(i));
  end

  // R2: one lamp lit
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lamp) == 1);
  // R4: simultaneous pulls leave the position alone
  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_a && pull_b && !round_clr) |=> $stable(lamp));
  // R6: a won round is frozen
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((won_a || won_b) && !round_clr) |=> $stable(lamp));
  // R3: a lone A pull moves one step toward index 0
  p_step_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_a && !pull_b && !won_a && !won_b && !round_clr) |=> lamp == ($past(lamp) >> 1));
  // R7: round reset re-centres
  p_recentre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    round_clr |=> lamp[MID]);
endmodule

// File: rtl/tow_tally.sv
module tow_tally #(
  parameter int TOP = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bump,
  output logic [3:0] digit
);
  import tow_pkg::*;
  localparam logic [3:0] TOPD = 4'(TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) digit <= '0;
    else if (bump) digit <= digit_bump(digit, TOPD);
  end

  // R9: digit never leaves the decimal range
  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    digit <= TOPD);
  // R8: digit moves only on a bump
  p_only_on_bump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(digit));
  // R8: a bump below the top adds exactly one
  p_add_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && digit < TOPD) |=> digit == 4'($past(digit) + 4'd1));
endmodule

// File: rtl/tow_game.sv
module tow_game #(
  parameter int LAMPS         = 9,
  parameter int STABLE_CYCLES = 500000,
  parameter int DIGIT_TOP     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             round_clr,
  input  logic             btn_a,
  input  logic             btn_b,
  output logic [LAMPS-1:0] lamp,
  output logic             won_a,
  output logic             won_b,
  output logic [3:0]       wins_a,
  output logic [3:0]       wins_b
);
  localparam int PLAYERS = 2;

  logic [PLAYERS-1:0] raw, pull, take;
  logic [3:0] digits [PLAYERS];

  assign raw = {btn_b, btn_a};

  for (genvar p = 0; p < PLAYERS; p++) begin : g_player
    tow_btn_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw[p]), .press(pull[p]));
    tow_tally #(.TOP(DIGIT_TOP)) u_tally (
      .clk(clk), .rst_n(rst_n), .bump(take[p]), .digit(digits[p]));
  end

  tow_rope #(.LAMPS(LAMPS)) u_rope (
    .clk(clk), .rst_n(rst_n), .round_clr(round_clr),
    .pull_a(pull[0]), .pull_b(pull[1]), .lamp(lamp),
    .won_a(won_a), .won_b(won_b), .take_a(take[0]), .take_b(take[1]));

  assign wins_a = digits[0];
  assign wins_b = digits[1];

  // R8: A's digit counts on the edge A's win appears (unless saturated)
  p_win_counts_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take[0] |=> (won_a && (wins_a == 4'($past(wins_a) + 4'd1) || wins_a == 4'(DIGIT_TOP))));
  // R5: the two win flags never coexist
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(won_a && won_b));
  // R7: round reset keeps the digits
  p_clr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    round_clr |=> ($stable(wins_a) && $stable(wins_b)));
endmodule

// File: tb/sim_tow_game.sv
module sim_tow_game;
  localparam int ST = 8;
  localparam int HOLD = ST + 8;

  logic clk = 0, rst_n = 0, round_clr = 0, btn_a = 0, btn_b = 0;
  logic [8:0] lamp;
  logic won_a, won_b;
  logic [3:0] wins_a, wins_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tow_game #(.LAMPS(9), .STABLE_CYCLES(ST), .DIGIT_TOP(9)) u0 (
    .clk(clk), .rst_n(rst_n), .round_clr(round_clr), .btn_a(btn_a), .btn_b(btn_b),
    .lamp(lamp), .won_a(won_a), .won_b(won_b), .wins_a(wins_a), .wins_b(wins_b));

  // {press_a, press_b, exp_index[3:0], exp_wins_a[3:0], exp_wins_b[3:0]}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {2'b10, 4'd3, 4'd0, 4'd0},   // R3
    {2'b10, 4'd2, 4'd0, 4'd0},   // R3
    {2'b01, 4'd3, 4'd0, 4'd0},   // R3
    {2'b11, 4'd3, 4'd0, 4'd0},   // R4
    {2'b10, 4'd2, 4'd0, 4'd0},
    {2'b10, 4'd1, 4'd0, 4'd0},
    {2'b10, 4'd0, 4'd1, 4'd0},   // R5 R8
    {2'b01, 4'd0, 4'd1, 4'd0},   // R6
    {2'b11, 4'd0, 4'd1, 4'd0}    // R6 R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press(input logic a, input logic b, input int hold);
    @(negedge clk); btn_a = a; btn_b = b;
    repeat (hold) @(negedge clk);
    btn_a = 0; btn_b = 0;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic rclr();
    @(negedge clk); round_clr = 1;
    @(negedge clk); round_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lamp", lamp, 9'b000010000);
    chk("R1 flags", {won_a, won_b}, 2'b00);
    chk("R1 digits", {wins_a, wins_b}, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      press(VEC[i][13], VEC[i][12], HOLD);
      chk($sformatf("R3/R4/R6 vec%0d lamp", i), lamp, 9'(1) << VEC[i][11:8]);
      chk($sformatf("R2 vec%0d onehot", i), $countones(lamp), 1);
      chk($sformatf("R8 vec%0d digits", i), {wins_a, wins_b}, {VEC[i][7:4], VEC[i][3:0]});
      chk($sformatf("R5 vec%0d flags", i), {won_a, won_b},
          {VEC[i][11:8] == 4'd0, VEC[i][11:8] == 4'd8});
    end

    // R7: round reset
    rclr();
    @(negedge clk);
    chk("R7 lamp", lamp, 9'b000010000);
    chk("R7 flags", {won_a, won_b}, 2'b00);
    chk("R7 digits kept", {wins_a, wins_b}, 8'h10);

    // R10: short glitch ignored
    press(1, 0, 3);
    chk("R10 glitch ignored", lamp, 9'b000010000);
    // R10: long hold gives one step
    press(0, 1, 6 * HOLD);
    chk("R10 hold one step", lamp, 9'b000100000);

    // R5/R8: B wins, digit changes on the arrival edge
    for (int k = 0; k < 2; k++) press(0, 1, HOLD);
    @(negedge clk); btn_b = 1;
    while (!won_b) @(negedge clk);
    chk("R8 B digit same edge", wins_b, 4'd1);
    chk("R5 won_b", {won_a, won_b, lamp[8]}, 3'b011);
    @(negedge clk); btn_b = 0;
    repeat (HOLD) @(negedge clk);
    press(0, 1, HOLD);
    chk("R6 B frozen digit", wins_b, 4'd1);
    press(1, 0, HOLD);
    chk("R6 B frozen lamp", lamp, 9'b100000000);

    // R9: A wins nine more rounds, digit holds at 9
    for (int r = 0; r < 9; r++) begin
      rclr();
      for (int k = 0; k < 4; k++) press(1, 0, HOLD);
    end
    chk("R9 saturated", wins_a, 4'd9);
    chk("R9 B untouched", wins_b, 4'd1);

    // R1: full clear
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 clear digits", {wins_a, wins_b}, 8'h00);
    chk("R1 clear lamp", lamp, 9'b000010000);
    rst_n = 1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule